// File: doc/BRIEF.md
# Frame-Aligned Transmit Enable Controller

This block holds the control word of a serial audio port and produces the enable that the transmitter actually uses. The control word sits in the bus clock domain. The transmitter runs on the bit clock. Software writes the word through a plain write strobe and data bus and can read it back at any time. Bits 12:0 are stored, and the upper bits always read as zero.

In the bit-clock domain, the requested transmit enable goes to the transmitter in one of two ways. It can be applied directly. It can instead be sampled on each rising edge of frame sync, so that the transmitter starts and stops only on frame boundaries. A frame-clock-disable option splits the two directions. Switching on may use the direct request, while switching off always waits for the next frame boundary. Gated mode and the AC97 framing mode skip the frame-aligned sampling.

A status output shows the copy of the enable that was captured at frame sync.

Top module: `txfs_tx_enable_ctrl`

## Requirements
- R1: After reset, `bus_rdata`, `cfg_out`, `tx_en` and `tx_en_latched` are all zero.
- R2: A write stores `bus_wdata[12:0]`, which can be read back on `bus_rdata[12:0]` from the next bus clock. Bits 31:13 of `bus_rdata` read zero whatever is written to them.
- R3: While bit 0 (module enable) is clear, `tx_en` and `tx_en_latched` fall to zero within 6 bit-clock cycles and stay there.
- R4: With bit 12 (frame-aligned enable) clear, `tx_en` follows bit 1 (transmit request) within 6 bit-clock cycles of the write, without any frame sync.
- R5: With bit 12 set and bits 10, 6:5 and `ac97_mode` inactive, `tx_en_latched` takes the value of bit 1 only on a rising edge of `frame_sync`, and `tx_en` equals `tx_en_latched`. A request written at least 6 bit clocks before the edge is captured at that edge and appears on `tx_en` within 4 bit clocks after it.
- R6: With bits 12 and 10 (transmit frame-clock disable) set and bit 4 (synchronous mode) clear, setting bit 1 raises `tx_en` without a frame sync. Clearing bit 1 keeps `tx_en` high until the next frame-sync rising edge.
- R7: With bits 12, 10 and 4 set, the direct switch-on of R6 is used only while `rx_enabled` is low. While `rx_enabled` is high, switching on waits for frame sync.
- R8: When bits 6:5 equal 2'b11 (gated mode), or when `ac97_mode` is high, `tx_en` follows bit 1 directly even with bit 12 set.
- R9: Frame sync acts only on its rising edge. Holding `frame_sync` high does not capture a later change of bit 1.
- R10: `cfg_out` mirrors the stored bits 12:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Synchronous active-low reset, used by both clock domains |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word read-back, upper bits zero |
| cfg_out | output | 13 | Stored control fields for the rest of the port |
| bit_clk | input | 1 | Serial bit clock |
| frame_sync | input | 1 | Frame-sync level, in the bit-clock domain |
| rx_enabled | input | 1 | Receiver running, in the bit-clock domain |
| ac97_mode | input | 1 | AC97 framing selected elsewhere |
| tx_en | output | 1 | Effective transmitter enable (bit-clock domain) |
| tx_en_latched | output | 1 | Transmit request as captured at the last frame sync |

## Verification
The assertions assume that reset is held for several cycles of both clocks, so every flop in each domain starts from a known value. They also assume that the mode fields, `ac97_mode` and `rx_enabled` change only while the block is settled, because the bit-clock checks relate the synchronized copies of those fields one cycle apart. The stimulus writes one control word, then waits at least six bit clocks before it pulses frame sync or samples any output. It changes the mode inputs only between those settled steps, so every value stays clear of the crossing window.

// File: rtl/txfs_pkg.sv
// Package: field positions and shared constants of the transmit-enable
// control word. Assumes a 32-bit bus with the low 13 bits implemented.
package txfs_pkg;
    localparam int CR_W    = 32;
    localparam int FIELD_W = 13;

    localparam int F_MOD_EN   = 0;
    localparam int F_TX_REQ   = 1;
    localparam int F_RX_REQ   = 2;
    localparam int F_NET      = 3;
    localparam int F_SYN      = 4;
    localparam int F_MODE_LO  = 5;
    localparam int F_MODE_HI  = 6;
    localparam int F_SYSCLK   = 7;
    localparam int F_TWO_CH   = 8;
    localparam int F_CLK_IDLE = 9;
    localparam int F_TX_FCD   = 10;
    localparam int F_RX_FCD   = 11;
    localparam int F_FS_ALIGN = 12;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ALT1   = 2'b01,
        MODE_ALT2   = 2'b10,
        MODE_GATED  = 2'b11
    } port_mode_e;

    // Number of control bits carried into the bit-clock domain
    localparam int BIT_CFG_W = 6;
endpackage

// File: rtl/txfs_ctrl_reg.sv
// Control word storage in the bus clock domain.
// Holds the implemented low fields; upper read-back bits are zero.
// Assumes a single-cycle write strobe with data valid in that cycle.
module txfs_ctrl_reg
    import txfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] fields,
    output logic [CR_W-1:0]    rdata
);
    localparam int PAD_W = CR_W - FIELD_W;

    // Store the written fields; reset clears all of them
    always_ff @(posedge clk) begin
        if (!rst_n)
            fields <= '0;
        else if (wr)
            fields <= wdata;
    end

    // Read-back with reserved bits forced to zero
    always_comb rdata = {{PAD_W{1'b0}}, fields};
endmodule

// File: rtl/txfs_sync.sv
// Multi-stage register chain used both as a clock-domain synchronizer
// and as a plain delay line. Assumes the input is quasi-static when
// W > 1 so bits crossing together need no coherence protocol.
module txfs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the input through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stg[i] <= stg[i-1];
        end
    end

    always_comb q = stg[STAGES-1];
endmodule

// File: rtl/txfs_te_latch.sv
// Bit-clock-domain core: detects the frame-sync rising edge, delays the
// synchronized transmit request to form the setup window, captures it
// at frame sync and registers the effective enable.
// Assumes frame_sync is generated in the bit-clock domain.
module txfs_te_latch #(
    parameter int SETUP_DLY = 1
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic en_bit,
    input  logic te_bit,
    input  logic frame_sync,
    input  logic bypass,
    input  logic direct_ok,
    output logic fs_rise,
    output logic te_d,
    output logic latched,
    output logic tx_en
);
    logic fs_q;
    logic fs_prev;

    // Delay the request so only settled values meet the capture point
    txfs_sync #(.W(1), .STAGES(SETUP_DLY)) u_setup_dly (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .d     (te_bit),
        .q     (te_d)
    );

    // Sample frame sync and keep its previous value for edge detection
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            fs_q    <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            fs_q    <= frame_sync;
            fs_prev <= fs_q;
        end
    end

    always_comb fs_rise = fs_q & ~fs_prev;

    // Capture the delayed request at each frame-sync rising edge
    always_ff @(posedge bit_clk) begin
        if (!rst_n)
            latched <= 1'b0;
        else if (!en_bit)
            latched <= 1'b0;
        else if (fs_rise)
            latched <= te_d;
    end

    // Effective enable: direct, framed, or direct-on / framed-off
    always_ff @(posedge bit_clk) begin
        if (!rst_n)
            tx_en <= 1'b0;
        else if (!en_bit)
            tx_en <= 1'b0;
        else if (bypass)
            tx_en <= te_bit;
        else
            tx_en <= latched | (direct_ok & te_bit);
    end
endmodule

// File: rtl/txfs_tx_enable_ctrl.sv
// Top: control word on the bus side, synchronized control bits on the
// bit-clock side, and the frame-aligned transmit enable.
// Assumes rst_n is held across several cycles of both clocks and that
// mode fields change only while the transmitter is settled.
module txfs_tx_enable_ctrl
    import txfs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_DLY   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [CR_W-1:0]    bus_wdata,
    output logic [CR_W-1:0]    bus_rdata,
    output logic [FIELD_W-1:0] cfg_out,
    input  logic               bit_clk,
    input  logic               frame_sync,
    input  logic               rx_enabled,
    input  logic               ac97_mode,
    output logic               tx_en,
    output logic               tx_en_latched
);
    logic [FIELD_W-1:0]   fields;
    logic [BIT_CFG_W-1:0] cfg_bus;
    logic [BIT_CFG_W-1:0] cfg_bit;
    logic                 unused_hi;
    logic en_bit, te_bit, align_bit, tfcd_bit, syn_bit, gated_bit;
    logic bypass, direct_ok, fs_rise, te_d;

    assign unused_hi = ^bus_wdata[CR_W-1:FIELD_W];

    txfs_ctrl_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .wdata  (bus_wdata[FIELD_W-1:0]),
        .fields (fields),
        .rdata  (bus_rdata)
    );

    // Pack the bits the bit-clock side needs, decoding gated mode first
    always_comb begin
        cfg_bus = {
            (port_mode_e'(fields[F_MODE_HI:F_MODE_LO]) == MODE_GATED),
            fields[F_SYN],
            fields[F_TX_FCD],
            fields[F_FS_ALIGN],
            fields[F_TX_REQ],
            fields[F_MOD_EN]
        };
    end

    txfs_sync #(.W(BIT_CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .d     (cfg_bus),
        .q     (cfg_bit)
    );

    assign {gated_bit, syn_bit, tfcd_bit, align_bit, te_bit, en_bit} = cfg_bit;

    // Mode decode: when to skip frame capture, when direct switch-on is allowed
    always_comb begin
        bypass    = ~align_bit | gated_bit | ac97_mode;
        direct_ok = tfcd_bit & (~syn_bit | ~rx_enabled);
    end

    txfs_te_latch #(.SETUP_DLY(SETUP_DLY)) u_core (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .en_bit     (en_bit),
        .te_bit     (te_bit),
        .frame_sync (frame_sync),
        .bypass     (bypass),
        .direct_ok  (direct_ok),
        .fs_rise    (fs_rise),
        .te_d       (te_d),
        .latched    (tx_en_latched),
        .tx_en      (tx_en)
    );

    assign cfg_out = fields;
endmodule

// File: rtl/txfs_tx_enable_ctrl_chk.sv
// Checker bound into the top: relates the bus write to read-back and
// the bit-clock capture and enable paths cycle by cycle.
// Assumes reset spans several cycles of both clocks.
module txfs_tx_enable_ctrl_chk
    import txfs_pkg::*;
(
    input logic               clk,
    input logic               bit_clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [CR_W-1:0]    bus_wdata,
    input logic [CR_W-1:0]    bus_rdata,
    input logic               en_bit,
    input logic               te_bit,
    input logic               te_d,
    input logic               fs_rise,
    input logic               bypass,
    input logic               direct_ok,
    input logic               latched,
    input logic               tx_en
);
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> bus_rdata == {{(CR_W-FIELD_W){1'b0}}, $past(bus_wdata[FIELD_W-1:0])}); // R2

    AST_DISABLED_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !en_bit |=> (!tx_en && !latched)); // R3

    AST_DIRECT_FOLLOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (en_bit && bypass) |=> tx_en == $past(te_bit)); // R4

    AST_FS_CAPTURE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (en_bit && fs_rise) |=> latched == $past(te_d)); // R5

    AST_HOLD_BETWEEN_FS: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (en_bit && !fs_rise) |=> $stable(latched)); // R9

    AST_FRAMED_ONLY: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (en_bit && !bypass && !direct_ok) |=> tx_en == $past(latched)); // R5

    AST_DIRECT_ON: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (en_bit && !bypass && direct_ok && te_bit) |=> tx_en); // R6
endmodule

bind txfs_tx_enable_ctrl txfs_tx_enable_ctrl_chk u_chk (
    .clk       (clk),
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .en_bit    (en_bit),
    .te_bit    (te_bit),
    .te_d      (te_d),
    .fs_rise   (fs_rise),
    .bypass    (bypass),
    .direct_ok (direct_ok),
    .latched   (tx_en_latched),
    .tx_en     (tx_en)
);

// File: tb/txfs_tx_enable_ctrl_bench.sv
module txfs_tx_enable_ctrl_bench;
    logic        clk = 1'b0;
    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [12:0] cfg_out;
    logic        frame_sync = 1'b0;
    logic        rx_enabled = 1'b0;
    logic        ac97_mode = 1'b0;
    logic        tx_en;
    logic        tx_en_latched;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;      // 50 MHz bus clock
    always #40 bit_clk = ~bit_clk;

    txfs_tx_enable_ctrl u_txfs_tx_enable_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .cfg_out       (cfg_out),
        .bit_clk       (bit_clk),
        .frame_sync    (frame_sync),
        .rx_enabled    (rx_enabled),
        .ac97_mode     (ac97_mode),
        .tx_en         (tx_en),
        .tx_en_latched (tx_en_latched)
    );

    // Vector: write word, side inputs, fs pulse, expected before/after fs
    typedef struct packed {
        logic [12:0] w;
        logic        ac97;
        logic        rxen;
        logic        fs;
        logic        pre_tx;
        logic        post_tx;
        logic        post_lat;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{13'h0003, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 direct on
        '{13'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 direct off
        '{13'h1003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 on at fs
        '{13'h1001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 off at fs
        '{13'h1403, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 direct on
        '{13'h1401, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 framed off
        '{13'h1413, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 rx on: wait
        '{13'h1411, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
        '{13'h1413, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R7 rx off: direct
        '{13'h1411, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
        '{13'h1063, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 gated
        '{13'h1061, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 gated
        '{13'h1003, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R8 ac97
        '{13'h1001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 ac97
        '{13'h1003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 no fs, no change
        '{13'h1003, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
        '{13'h1002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R3 module off
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_bclk(input int n);
        for (int i = 0; i < n; i++) @(negedge bit_clk);
    endtask

    task automatic fs_pulse();
        @(negedge bit_clk);
        frame_sync = 1'b1;
        @(negedge bit_clk);
        frame_sync = 1'b0;
        wait_bclk(3);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        wait_bclk(10);
        rst_n = 1'b1;
        wait_bclk(2);

        // R1 reset state
        @(negedge clk);
        check("R1", "rdata", bus_rdata, 32'h0);
        check("R1", "cfg_out", {19'h0, cfg_out}, 32'h0);
        check("R1", "tx_en", {31'h0, tx_en}, 32'h0);
        check("R1", "latched", {31'h0, tx_en_latched}, 32'h0);

        // Vector walk covering R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            ac97_mode  = VEC[v].ac97;
            rx_enabled = VEC[v].rxen;
            bus_write({19'h0, VEC[v].w});
            wait_bclk(6);
            check("R3/R4/R5/R6/R7/R8", $sformatf("vec %0d tx_en before fs", v),
                  {31'h0, tx_en}, {31'h0, VEC[v].pre_tx});
            if (VEC[v].fs) fs_pulse();
            else wait_bclk(4);
            check("R3/R4/R5/R6/R7/R8", $sformatf("vec %0d tx_en after fs", v),
                  {31'h0, tx_en}, {31'h0, VEC[v].post_tx});
            check("R3/R5", $sformatf("vec %0d latched", v),
                  {31'h0, tx_en_latched}, {31'h0, VEC[v].post_lat});
        end
        ac97_mode  = 1'b0;
        rx_enabled = 1'b0;

        // R2 reserved bits ignore writes
        bus_write(32'hFFFF_E000);
        @(negedge clk);
        check("R2", "reserved-only write", bus_rdata, 32'h0);
        // R2 and R10 full write read-back
        bus_write(32'hFFFF_FFFF);
        @(negedge clk);
        check("R2", "readback", bus_rdata, 32'h0000_1FFF);
        check("R10", "cfg_out", {19'h0, cfg_out}, 32'h0000_1FFF);
        bus_write(32'h0000_0A5A);
        @(negedge clk);
        check("R10", "cfg_out pattern", {19'h0, cfg_out}, 32'h0000_0A5A);

        // R9: frame sync held high captures once only
        bus_write(32'h0000_1001);
        wait_bclk(6);
        @(negedge bit_clk);
        frame_sync = 1'b1;
        wait_bclk(4);
        check("R9", "latched at held fs", {31'h0, tx_en_latched}, 32'h0);
        bus_write(32'h0000_1003);
        wait_bclk(8);
        check("R9", "no capture while fs high", {31'h0, tx_en_latched}, 32'h0);
        check("R9", "tx_en while fs high", {31'h0, tx_en}, 32'h0);
        @(negedge bit_clk);
        frame_sync = 1'b0;
        wait_bclk(2);
        @(negedge bit_clk);
        frame_sync = 1'b1;
        wait_bclk(4);
        check("R5", "capture at new edge", {31'h0, tx_en_latched}, 32'h1);
        check("R5", "tx_en at new edge", {31'h0, tx_en}, 32'h1);
        frame_sync = 1'b0;

        // R3 module disable clears both outputs with no frame sync
        bus_write(32'h0000_1002);
        wait_bclk(6);
        check("R3", "tx_en off", {31'h0, tx_en}, 32'h0);
        check("R3", "latched cleared", {31'h0, tx_en_latched}, 32'h0);

        // R1 reset mid-run
        bus_write(32'h0000_0003);
        wait_bclk(6);
        rst_n = 1'b0;
        wait_bclk(4);
        @(negedge clk);
        check("R1", "rdata after reset", bus_rdata, 32'h0);
        check("R1", "tx_en after reset", {31'h0, tx_en}, 32'h0);
        rst_n = 1'b1;
        wait_bclk(2);

        done = 1'b1;
        finish_run();
    end
endmodule